// File: doc/BRIEF.md
# Conflict-Terminated Interval Recorder

This unit sits beside one processor core and cuts its execution into intervals whose global order can be recovered afterwards. Every memory operation the core performs marks its cache line in one of two small probabilistic sets held for the current interval. Loads go to a read set and stores go to a write set. Coherence requests from other cores are snooped and tested against these sets.

A snooped request that could touch data this interval has already used closes the interval. The unit then emits one frame record holding the closed interval's sequence number and the value of the global cycle counter in that cycle. Sorting frames from all cores by that timestamp gives a total order of intervals.

The frame leaves through a valid/ready port backed by a one-entry holding register. While that register is occupied and not draining, a snoop that would close another interval is refused through `snp_ready`. The source must hold the snoop until it is taken.

Top module: `ivl_recorder`

## Requirements
- R1: A performed memory operation (`mem_vld`=1) sets two bits in the current interval's signature: the read signature when `mem_is_store`=0, the write signature when it is 1. With line = addr >> 6, the bit indices are i0 = line[8:0] and i1 = line[17:9] XOR line[8:0]. A line is a member of a 512-bit signature when both of its bits are set.
- R2: A snooped read (`snp_vld`=1, `snp_inv`=0) conflicts only when its line is a member of the write signature. A snooped read that hits only the read signature leaves the interval open.
- R3: A snooped invalidate (`snp_inv`=1) conflicts when its line is a member of either signature.
- R4: A conflict that is accepted terminates the interval. In the next cycle `log_valid` is 1, `log_seq` holds the interval's sequence number, and `log_ts` holds the value `ts_in` had in the terminating cycle.
- R5: On the same clock edge as a termination, both signatures are cleared and the sequence number increases by one. A memory operation performed in the terminating cycle is recorded in the new interval.
- R6: While `log_valid`=1 and `log_ready`=0, the frame outputs hold steady. In that state a conflicting snoop sees `snp_ready`=0 and closes no interval.
- R7: After reset, `log_valid` is 0, the sequence number is 0 and both signatures are empty.
- R8: When a frame drains (`log_ready`=1) in the same cycle as a new conflict, the new conflict is accepted and its frame appears in the next cycle with no gap.
- R9: A snoop that does not conflict changes neither the signatures nor the sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_vld | input | 1 | A memory operation was performed this cycle |
| mem_addr | input | 32 | Byte address of the performed operation |
| mem_is_store | input | 1 | 1 = store, 0 = load |
| snp_vld | input | 1 | A snooped coherence request is present |
| snp_addr | input | 32 | Byte address of the snooped request |
| snp_inv | input | 1 | 1 = invalidate, 0 = read |
| snp_ready | output | 1 | Snoop taken this cycle; 0 means hold it |
| ts_in | input | 32 | Global cycle timestamp |
| log_valid | output | 1 | A frame record is presented |
| log_ready | input | 1 | The sink takes the frame this cycle |
| log_seq | output | 16 | Interval sequence number of the frame |
| log_ts | output | 32 | Global timestamp at termination |

## Verification
Two events can land on the same edge and the design has to handle both. A memory operation can be performed in the very cycle a snoop ends the interval. A held frame can also drain while a fresh conflict arrives. The bench provokes the first case by pairing a store with a conflicting snoop, then snooping the stored line again: that snoop must close a second interval. It provokes the second case by raising `log_ready` in the cycle a conflict arrives, and a frame must follow with no gap. A behavioural model of both signatures, the sequence number and the holding register judges every cycle, including long random runs with a small address pool and random sink stalls.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
   localparam int unsigned SEQ_W = 16;
   localparam int unsigned TS_W  = 32;

   typedef struct packed {
      logic [SEQ_W-1:0] seq;
      logic [TS_W-1:0]  ts;
   } ivl_frame_t;

   typedef enum logic [0:0] {
      SIG_RD = 1'b0,
      SIG_WR = 1'b1
   } sig_kind_e;
endpackage

// File: rtl/ivl_line_hash.sv
module ivl_line_hash #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LINE_OFF = 6,
   parameter int unsigned IDX_W    = 9
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx0,
   output logic [IDX_W-1:0]  idx1
);
   localparam int unsigned LINE_W = ADDR_W - LINE_OFF;

   generate
      if (LINE_W < 2 * IDX_W) begin : g_bad_width
         $error("ivl_line_hash: line address narrower than two indices");
      end
   endgenerate

   logic [LINE_W-1:0] line;

   always_comb begin
      line = addr[ADDR_W-1:LINE_OFF];
      idx0 = line[IDX_W-1:0];
      idx1 = line[2*IDX_W-1:IDX_W] ^ line[IDX_W-1:0];
   end
endmodule

// File: rtl/ivl_sig_bank.sv
module ivl_sig_bank #(
   parameter int unsigned SIG_BITS = 512,
   parameter int unsigned IDX_W    = $clog2(SIG_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ins,
   input  logic [IDX_W-1:0] ins_i0,
   input  logic [IDX_W-1:0] ins_i1,
   input  logic [IDX_W-1:0] tst_i0,
   input  logic [IDX_W-1:0] tst_i1,
   output logic             hit
);
   generate
      if (SIG_BITS != (1 << IDX_W)) begin : g_bad_size
         $error("ivl_sig_bank: SIG_BITS must equal 2**IDX_W");
      end
   endgenerate

   logic [SIG_BITS-1:0] sig_q;
   logic [SIG_BITS-1:0] sig_d;
   logic [SIG_BITS-1:0] ins_mask;

   always_comb begin
      ins_mask = '0;
      if (ins) begin
         ins_mask[ins_i0] = 1'b1;
         ins_mask[ins_i1] = 1'b1;
      end
      sig_d = (clr ? '0 : sig_q) | ins_mask;
      hit   = sig_q[tst_i0] & sig_q[tst_i1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sig_q <= '0;
      else        sig_q <= sig_d;
   end

   assert_insert_member_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ins |=> (sig_q[$past(ins_i0)] && sig_q[$past(ins_i1)]));

   assert_clear_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ins) |=> ($countones(sig_q) == 0));

   assert_keep_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ins) |=> $stable(sig_q));
endmodule

// File: rtl/ivl_frame_buf.sv
module ivl_frame_buf
   import ivl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  ivl_frame_t din,
   output logic       can_load,
   output logic       out_valid,
   input  logic       out_ready,
   output ivl_frame_t dout
);
   logic       full_q;
   ivl_frame_t data_q;

   assign can_load  = !full_q || out_ready;
   assign out_valid = full_q;
   assign dout      = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (load) begin
         full_q <= 1'b1;
         data_q <= din;
      end else if (out_ready) begin
         full_q <= 1'b0;
      end
   end

   assert_hold_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(dout)));

   assert_load_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> can_load);
endmodule

// File: rtl/ivl_recorder.sv
module ivl_recorder
   import ivl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LINE_OFF = 6,
   parameter int unsigned SIG_BITS = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_vld,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_is_store,
   input  logic              snp_vld,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_inv,
   output logic              snp_ready,
   input  logic [TS_W-1:0]   ts_in,
   output logic              log_valid,
   input  logic              log_ready,
   output logic [SEQ_W-1:0]  log_seq,
   output logic [TS_W-1:0]   log_ts
);
   localparam int unsigned IDX_W  = $clog2(SIG_BITS);
   localparam int unsigned N_SIGS = 2;

   generate
      if (LINE_OFF >= ADDR_W) begin : g_bad_off
         $error("ivl_recorder: LINE_OFF must be below ADDR_W");
      end
   endgenerate

   logic [IDX_W-1:0] m_i0, m_i1, s_i0, s_i1;
   logic [N_SIGS-1:0] sig_hit;
   logic [N_SIGS-1:0] sig_ins;
   logic              conflict, term, buf_can_load;
   logic [SEQ_W-1:0]  seq_q;
   ivl_frame_t        frame_in, frame_out;

   ivl_line_hash #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .IDX_W(IDX_W)) u_mhash (
      .addr(mem_addr), .idx0(m_i0), .idx1(m_i1));

   ivl_line_hash #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .IDX_W(IDX_W)) u_shash (
      .addr(snp_addr), .idx0(s_i0), .idx1(s_i1));

   assign sig_ins[SIG_RD] = mem_vld && !mem_is_store;
   assign sig_ins[SIG_WR] = mem_vld &&  mem_is_store;

   generate
      for (genvar g = 0; g < N_SIGS; g++) begin : g_sig
         ivl_sig_bank #(.SIG_BITS(SIG_BITS), .IDX_W(IDX_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .clr(term), .ins(sig_ins[g]),
            .ins_i0(m_i0), .ins_i1(m_i1), .tst_i0(s_i0), .tst_i1(s_i1),
            .hit(sig_hit[g]));
      end
   endgenerate

   always_comb begin
      conflict  = snp_vld && (sig_hit[SIG_WR] || (snp_inv && sig_hit[SIG_RD]));
      term      = conflict && buf_can_load;
      snp_ready = !conflict || buf_can_load;
      frame_in.seq = seq_q;
      frame_in.ts  = ts_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    seq_q <= '0;
      else if (term) seq_q <= seq_q + 1'b1;
   end

   ivl_frame_buf u_fbuf (
      .clk(clk), .rst_n(rst_n), .load(term), .din(frame_in),
      .can_load(buf_can_load), .out_valid(log_valid), .out_ready(log_ready),
      .dout(frame_out));

   assign log_seq = frame_out.seq;
   assign log_ts  = frame_out.ts;

   assert_frame_content_R4: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> (log_valid && log_seq == $past(seq_q) && log_ts == $past(ts_in)));

   assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> (seq_q == $past(seq_q) + 1'b1));

   assert_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_ready |-> (log_valid && !log_ready));

   assert_seq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !term |=> $stable(seq_q));
endmodule

// File: tb/sim_ivl_recorder.sv
`timescale 1ns/1ps
module sim_ivl_recorder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_vld = 1'b0, mem_is_store = 1'b0;
   logic [31:0] mem_addr = '0;
   logic        snp_vld = 1'b0, snp_inv = 1'b0;
   logic [31:0] snp_addr = '0;
   logic        snp_ready;
   logic [31:0] ts_in = '0;
   logic        log_valid;
   logic        log_ready = 1'b0;
   logic [15:0] log_seq;
   logic [31:0] log_ts;

   int checks = 0;
   int errors = 0;

   bit          m_rd[512];
   bit          m_wr[512];
   int unsigned m_seq = 0;
   bit          m_full = 0;
   int unsigned m_fseq = 0;
   int unsigned m_fts = 0;
   int unsigned cyc = 0;

   always #2 clk = ~clk;

   ivl_recorder u0 (
      .clk(clk), .rst_n(rst_n), .mem_vld(mem_vld), .mem_addr(mem_addr),
      .mem_is_store(mem_is_store), .snp_vld(snp_vld), .snp_addr(snp_addr),
      .snp_inv(snp_inv), .snp_ready(snp_ready), .ts_in(ts_in),
      .log_valid(log_valid), .log_ready(log_ready), .log_seq(log_seq),
      .log_ts(log_ts));

   function automatic int unsigned hidx0(input logic [31:0] a);
      return (a / 64) % 512;
   endfunction

   function automatic int unsigned hidx1(input logic [31:0] a);
      return (((a / 64) / 512) % 512) ^ hidx0(a);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input bit mv, input logic [31:0] ma, input bit ms,
                       input bit sv, input logic [31:0] sa, input bit si,
                       input bit rdy, input string req);
      bit conf, can, term;
      int unsigned s0, s1, a0, a1;
      mem_vld = mv; mem_addr = ma; mem_is_store = ms;
      snp_vld = sv; snp_addr = sa; snp_inv = si;
      log_ready = rdy; ts_in = cyc;
      #1;
      s0 = hidx0(sa); s1 = hidx1(sa);
      conf = sv && ((m_wr[s0] && m_wr[s1]) || (si && m_rd[s0] && m_rd[s1]));
      can  = !m_full || rdy;
      term = conf && can;
      check(snp_ready == (!conf || can), req, "snp_ready", snp_ready, !conf || can);
      check(log_valid == m_full, req, "log_valid", log_valid, m_full);
      if (m_full && log_valid) begin
         check(log_seq == m_fseq[15:0], req, "log_seq", log_seq, m_fseq[15:0]);
         check(log_ts == m_fts, req, "log_ts", log_ts, m_fts);
      end
      @(posedge clk);
      if (m_full && rdy) m_full = 0;
      if (term) begin
         m_full = 1; m_fseq = m_seq; m_fts = cyc;
         m_seq = (m_seq + 1) % 65536;
         for (int i = 0; i < 512; i++) begin m_rd[i] = 0; m_wr[i] = 0; end
      end
      if (mv) begin
         a0 = hidx0(ma); a1 = hidx1(ma);
         if (ms) begin m_wr[a0] = 1; m_wr[a1] = 1; end
         else    begin m_rd[a0] = 1; m_rd[a1] = 1; end
      end
      cyc++;
      @(negedge clk);
   endtask

   localparam logic [31:0] A = 32'h0000_1040;
   localparam logic [31:0] B = 32'h0004_2080;
   localparam logic [31:0] C = 32'h0010_30C0;
   localparam logic [31:0] D = 32'h0020_4100;

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(log_valid == 1'b0, "R7", "log_valid after reset", log_valid, 0);
      check(snp_ready == 1'b1, "R7", "snp_ready after reset", snp_ready, 1);
      @(negedge clk);
      // R7: empty signatures, snoops to every test line find nothing
      step(0, 0, 0, 1, A, 1, 1, "R7");
      step(0, 0, 0, 1, B, 0, 1, "R9");
      // R1 R2: load A then snoop read A, no conflict
      step(1, A, 0, 0, 0, 0, 1, "R1");
      step(0, 0, 0, 1, A, 0, 1, "R2");
      step(0, 0, 0, 0, 0, 0, 1, "R9");
      // R3: invalidate to A closes interval 0
      step(0, 0, 0, 1, A, 1, 1, "R3");
      step(0, 0, 0, 0, 0, 0, 1, "R4");
      step(1, B, 1, 0, 0, 0, 1, "R1");
      step(0, 0, 0, 1, B, 0, 1, "R2");
      step(0, 0, 0, 0, 0, 0, 1, "R4");
      // R5: store C in the terminating cycle of a conflict on D
      step(1, D, 1, 0, 0, 0, 1, "R1");
      step(1, C, 1, 1, D, 0, 1, "R5");
      step(0, 0, 0, 1, D, 1, 1, "R5");
      step(0, 0, 0, 1, C, 0, 1, "R5");
      step(0, 0, 0, 0, 0, 0, 1, "R5");
      // R6: sink stalls, second conflict is refused
      step(1, A, 1, 0, 0, 0, 0, "R6");
      step(0, 0, 0, 1, A, 0, 0, "R6");
      step(1, B, 1, 0, 0, 0, 0, "R6");
      step(0, 0, 0, 1, B, 1, 0, "R6");
      step(0, 0, 0, 1, B, 1, 0, "R6");
      // R8: drain and accept in the same cycle
      step(0, 0, 0, 1, B, 1, 1, "R8");
      step(0, 0, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 1, "R8");
      // mixed random traffic over a small pool
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] pool [4];
         pool[0] = A; pool[1] = B; pool[2] = C; pool[3] = D;
         step(($urandom % 2) == 0, pool[$urandom % 4], ($urandom % 2) == 0,
              ($urandom % 3) == 0, pool[$urandom % 4], ($urandom % 2) == 0,
              ($urandom % 4) != 0, "R8");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule